// File: doc/BRIEF.md
# Display Panel Sync and Enable Timing Generator

This block produces the timing signals a display panel needs, advancing by one step for each pixel-clock strobe it receives. A single line/frame engine serves two panel styles. In the sync-pulse style (`mode_active = 1`) it drives a vertical sync, a horizontal sync and a data enable. In the clocked-frame style (`mode_active = 0`) it drives a frame clock that spans the whole first line of each frame, and a line clock.

Each line has four phases in a fixed order:

- pixels, lasting `line_pix + 1` strobes;
- end-of-line wait, lasting `hfront + 1` strobes;
- line pulse, lasting `hpulse + 1` strobes;
- beginning-of-line wait, lasting `hback + 1` strobes.

In sync-pulse style a frame has three parts in order:

- `frame_lines + 1` pixel lines;
- `vfront + 1` end-of-frame wait lines;
- `vpulse + 1` frame pulse lines.

In clocked-frame style a frame is only its pixel lines.

Every output has its own polarity select. A pixel-clock output marks the launch edge that the designer selects. A data-valid strobe marks each pixel that is sent.

Top module: `lcd_sync_gen`

## Requirements
- R1: While `rst_n` is low, the pins hold fixed levels: `frame_o` = `pol_vs`, `line_o` = `pol_hs`, `dvalid_o` = 0, and `pclk_o` = `pol_pc`. `oe_o` equals `pol_oe` in sync-pulse style and 0 in clocked-frame style. After release, the engine starts at the beginning-of-line wait of the first end-of-frame wait line.
- R2: A line is made of pixels (`line_pix+1` strobes), then the end-of-line wait (`hfront+1`), then the line pulse (`hpulse+1`), then the beginning-of-line wait (`hback+1`). The line signal is active only during the line pulse. This holds in both styles.
- R3: In sync-pulse style, a frame is `frame_lines+1` pixel lines, then `vfront+1` wait lines, then `vpulse+1` pulse lines. The frame signal is active only during the pulse lines. Line boundaries fall on the first pixel strobe of a line.
- R4: In clocked-frame style, the frame signal goes active at the first pixel strobe of line 0 and goes inactive at the first pixel strobe of line 1. Frames then repeat with no wait or pulse lines. The one exception is the end-of-frame wait that follows reset.
- R5: `frame_o` equals the active state XOR `pol_vs`, and `line_o` equals the active state XOR `pol_hs`. A polarity bit of 0 means the pin is active high.
- R6: In sync-pulse style, the enable is active exactly during the pixel phase of pixel lines, and `oe_o` equals that state XOR `pol_oe`.
- R7: In clocked-frame style, `oe_o` is held at 0 whatever the value of `pol_oe`.
- R8: `dvalid_o` is high exactly in a cycle where `pix_en` is high and the engine is in the pixel phase of a pixel line. In sync-pulse style this means the enable is active.
- R9: `pclk_o` XOR `pol_pc` is 1 in the cycle after each `pix_en` strobe and 0 otherwise. State changes therefore line up with a rising `pclk_o` when `pol_pc` = 0 and with a falling `pclk_o` when `pol_pc` = 1.
- R10: Without a `pix_en` strobe, no phase or line position advances, and `frame_o` and `line_o` keep their levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | One-cycle strobe per pixel period; never high on two consecutive cycles |
| mode_active | input | 1 | 1 = sync-pulse style, 0 = clocked-frame style |
| pol_vs | input | 1 | Frame signal polarity (1 = active low) |
| pol_hs | input | 1 | Line signal polarity (1 = active low) |
| pol_pc | input | 1 | Pixel clock launch edge (0 = rising, 1 = falling) |
| pol_oe | input | 1 | Enable polarity (1 = active low) |
| line_pix | input | HW | Pixels per line minus one |
| hfront | input | HW | End-of-line wait strobes minus one |
| hpulse | input | HW | Line pulse strobes minus one |
| hback | input | HW | Beginning-of-line wait strobes minus one |
| frame_lines | input | VW | Pixel lines per frame minus one |
| vfront | input | VW | End-of-frame wait lines minus one |
| vpulse | input | VW | Frame pulse lines minus one |
| frame_o | output | 1 | Vertical sync or frame clock |
| line_o | output | 1 | Horizontal sync or line clock |
| oe_o | output | 1 | Data enable (sync-pulse style only) |
| pclk_o | output | 1 | Pixel clock |
| dvalid_o | output | 1 | Strobe for each pixel sent |

## Verification
The bench builds the block with HW = 6 and VW = 5 and keeps every programmed count between 0 and 5. A full frame, including its wait and pulse lines, therefore completes within a few hundred cycles. Each configuration crosses several frame and line wrap points in both styles. The all-zero counts, where every phase lasts one strobe, are reached as well. A bench model that counts the pixel position and the line index predicts every output in every cycle.

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen #(
  parameter int HW = 10,
  parameter int VW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic          mode_active,
  input  logic          pol_vs,
  input  logic          pol_hs,
  input  logic          pol_pc,
  input  logic          pol_oe,
  input  logic [HW-1:0] line_pix,
  input  logic [HW-1:0] hfront,
  input  logic [HW-1:0] hpulse,
  input  logic [HW-1:0] hback,
  input  logic [VW-1:0] frame_lines,
  input  logic [VW-1:0] vfront,
  input  logic [VW-1:0] vpulse,
  output logic          frame_o,
  output logic          line_o,
  output logic          oe_o,
  output logic          pclk_o,
  output logic          dvalid_o
);
  typedef enum logic [1:0] {H_PIX, H_FRONT, H_PULSE, H_BACK} hph_t;
  typedef enum logic [1:0] {V_PIX, V_FRONT, V_PULSE} vph_t;

  hph_t          hph;
  vph_t          vph;
  logic [HW-1:0] hcnt, hlim;
  logic [VW-1:0] vcnt, vlim;
  logic          pclk_q;

  always_comb
    case (hph)
      H_PIX:   hlim = line_pix;
      H_FRONT: hlim = hfront;
      H_PULSE: hlim = hpulse;
      default: hlim = hback;
    endcase

  always_comb
    case (vph)
      V_PIX:   vlim = frame_lines;
      V_FRONT: vlim = vfront;
      default: vlim = vpulse;
    endcase

  wire h_end     = hcnt >= hlim;
  wire v_end     = vcnt >= vlim;
  wire line_tick = pix_en && hph == H_BACK && h_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hph    <= H_BACK;
      hcnt   <= '0;
      vph    <= V_FRONT;
      vcnt   <= '0;
      pclk_q <= 1'b0;
    end else begin
      pclk_q <= pix_en;
      if (pix_en) begin
        if (h_end) begin
          hcnt <= '0;
          hph  <= hph_t'(hph + 2'd1);
        end else begin
          hcnt <= hcnt + HW'(1);
        end
      end
      if (line_tick) begin
        if (v_end) begin
          vcnt <= '0;
          case (vph)
            V_PIX:   vph <= mode_active ? V_FRONT : V_PIX;
            V_FRONT: vph <= mode_active ? V_PULSE : V_PIX;
            default: vph <= V_PIX;
          endcase
        end else begin
          vcnt <= vcnt + VW'(1);
        end
      end
    end
  end

  wire de_act = vph == V_PIX && hph == H_PIX;
  wire fr_act = mode_active ? (vph == V_PULSE) : (vph == V_PIX && vcnt == '0);

  assign frame_o  = fr_act ^ pol_vs;
  assign line_o   = (hph == H_PULSE) ^ pol_hs;
  assign oe_o     = mode_active & (de_act ^ pol_oe);
  assign pclk_o   = pclk_q ^ pol_pc;
  assign dvalid_o = pix_en & de_act;
endmodule

// File: rtl/lcd_sync_gen_chk.sv
module lcd_sync_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic pix_en,
  input logic mode_active,
  input logic pol_vs,
  input logic pol_hs,
  input logic pol_pc,
  input logic pol_oe,
  input logic frame_o,
  input logic line_o,
  input logic oe_o,
  input logic pclk_o,
  input logic dvalid_o
);
  p_pclk_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |=> ((pclk_o ^ pol_pc) == 1'b1));
  p_pclk_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ((pclk_o ^ pol_pc) == 1'b0));
  p_oe_passive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_active |-> (oe_o == 1'b0));
  p_dv_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dvalid_o |-> pix_en);
  p_dv_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_active && dvalid_o) |-> (oe_o != pol_oe));
  p_pulse_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_active && (line_o != pol_hs)) |-> (oe_o == pol_oe));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> (($stable(line_o) && $stable(frame_o)) ||
                 !$stable({pol_hs, pol_vs, mode_active})));
endmodule

bind lcd_sync_gen lcd_sync_gen_chk u_chk (.*);

// File: tb/tb_lcd_sync_gen.sv
`timescale 1ns/1ps
module tb_lcd_sync_gen;
  localparam int HW = 6;
  localparam int VW = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, pix_en, mode_active, pol_vs, pol_hs, pol_pc, pol_oe;
  logic [HW-1:0] line_pix, hfront, hpulse, hback;
  logic [VW-1:0] frame_lines, vfront, vpulse;
  logic frame_o, line_o, oe_o, pclk_o, dvalid_o;

  lcd_sync_gen #(.HW(HW), .VW(VW)) dut (.*);

  int total = 0, bad = 0;
  int P, E, S, B, LP, EF, VS, Hn, x, y;
  bit pe_prev;

  always @(posedge clk) begin
    if (!rst_n) begin
      x = P + E + S; y = LP; pe_prev = 1'b0;
    end else begin
      pe_prev = pix_en;
      if (pix_en) begin
        x++;
        if (x == Hn) begin
          x = 0; y++;
          if (mode_active) begin
            if (y == LP + EF + VS) y = 0;
          end else if (y == LP || y == LP + EF) y = 0;
        end
      end
    end
  end

  task automatic chk(string rq, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b (x=%0d y=%0d)", rq, act, exp, x, y);
    end
  endtask

  task automatic check_all();
    int hp;
    bit de, vpulse_l, fr;
    hp = x < P ? 0 : x < P + E ? 1 : x < P + E + S ? 2 : 3;
    de = (y < LP) && hp == 0;
    vpulse_l = y >= LP + EF;
    fr = mode_active ? vpulse_l : (y == 0);
    chk(mode_active ? "R3 R5 R10 frame" : "R4 R5 R10 frame", frame_o, fr ^ pol_vs);
    chk("R2 R5 R10 line", line_o, (hp == 2) ^ pol_hs);
    if (mode_active) chk("R6 enable", oe_o, de ^ pol_oe);
    else             chk("R7 enable", oe_o, 1'b0);
    chk("R8 dvalid", dvalid_o, pix_en & de);
    chk("R9 pclk", pclk_o, pe_prev ^ pol_pc);
  endtask

  task automatic run_cfg(bit m, bit [3:0] pols, int lp, int ef, int vs, int pp, int ef_h,
                         int hs, int bk, int ncyc);
    int gap;
    mode_active = m;
    {pol_vs, pol_hs, pol_pc, pol_oe} = pols;
    line_pix = HW'(pp); hfront = HW'(ef_h); hpulse = HW'(hs); hback = HW'(bk);
    frame_lines = VW'(lp); vfront = VW'(ef); vpulse = VW'(vs);
    P = pp + 1; E = ef_h + 1; S = hs + 1; B = bk + 1;
    LP = lp + 1; EF = ef + 1; VS = vs + 1; Hn = P + E + S + B;
    rst_n = 1'b0; pix_en = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R1 frame", frame_o, pol_vs);
      chk("R1 line", line_o, pol_hs);
      chk("R1 enable", oe_o, m ? pol_oe : 1'b0);
      chk("R1 dvalid", dvalid_o, 1'b0);
      chk("R1 pclk", pclk_o, pol_pc);
    end
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk); check_all();
    gap = 0;
    for (int c = 0; c < ncyc; c++) begin
      @(posedge clk); #1;
      if (gap > 0) begin pix_en = 1'b0; gap--; end
      else begin pix_en = 1'b1; gap = int'($urandom % 3) + 1; end
      @(negedge clk); check_all();
    end
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; pix_en = 1'b0;
    run_cfg(1'b1, 4'b0000, 0, 0, 0, 0, 0, 0, 0, 400);
    run_cfg(1'b0, 4'b0000, 0, 0, 0, 0, 0, 0, 0, 400);
    run_cfg(1'b0, 4'b0001, 2, 1, 1, 3, 1, 1, 1, 900);
    run_cfg(1'b1, 4'b1111, 3, 2, 2, 5, 3, 3, 3, 1500);
    for (int k = 0; k < 24; k++)
      run_cfg(1'($urandom % 2), 4'($urandom), int'($urandom % 4), int'($urandom % 3),
              int'($urandom % 3), int'($urandom % 6), int'($urandom % 4),
              int'($urandom % 4), int'($urandom % 4), 1000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule